// File: doc/BRIEF.md
# Pulse-Width Comparison Window Sequencer

This block sequences a pulse-width comparator that sits beside an injection-locked oscillator. It runs on the oscillator output divided by four. The division gives the comparator's time-to-voltage conversion enough gain while keeping the switching power low. An internal 3-bit phase counter steps through eight slots per injection interval. From the slot value the block decodes four one-hot timing outputs: an enable window, a reference window, a decision strobe and a reset strobe.

In the lower half of the interval (count bit 2 clear), the enable window at count 0 carries the frequency error and the reference window at count 1 spans one free-running period. In the upper half (counts 4 and 5), both windows span free-running periods, so their comparison exposes only the comparator's own mismatch. The 1-bit comparator result is latched at the close of each decision slot. Count bit 2 steers it either to the frequency-error output or to the mismatch-error output, and a one-cycle valid qualifier marks each new value.

An injection-edge marker re-aligns the counter so that slot 0 starts right at the injection edge. Since injection happens on both reference edges, a frequency decision and a mismatch decision come out every half reference period.

Top module: `pwc_window_seq`

## Requirements
- R1: While `rstN` is low, every output is 0. After `rstN` rises, the count is 0 (`enWin` high) until the first rising clock edge, and then it steps to 1 (`refWin` high).
- R2: Without a marker, the count advances by one per clock and wraps from 7 to 0. `enWin` is high at counts 0 and 4, `refWin` at 1 and 5, `decStrobe` at 2 and 6, and `rstStrobe` at 3 and 7. At most one of the four is high at a time.
- R3: When `injMark` is high at a rising edge, the next cycle is count 0 whatever the current count. A marker during the count-2 slot does not cancel that slot's frequency capture.
- R4: At the rising edge that closes count 2, `cmpDecision` is latched into `freqUpDn`. `freqValid` is high for exactly the following cycle (count 3), and `mmValid` stays low then.
- R5: At the rising edge that closes count 6, `cmpDecision` is latched into `mmUpDn`. `mmValid` is high for exactly the following cycle (count 7), and `freqValid` stays low then.
- R6: Outside those capture edges, `cmpDecision` has no effect: `freqUpDn` and `mmUpDn` hold their values, and both valid flags are low except in the cycle after their own capture.
- R7: A frequency capture leaves `mmUpDn` unchanged, and a mismatch capture leaves `freqUpDn` unchanged.
- R8: With no marker, exactly one `freqValid` pulse and one `mmValid` pulse occur in every eight consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkDiv | input | 1 | Oscillator output divided by four |
| rstN | input | 1 | Asynchronous active-low reset |
| injMark | input | 1 | Injection-edge marker; forces count 0 on the next cycle |
| cmpDecision | input | 1 | Comparator up/down result |
| enWin | output | 1 | Enable window (counts 0 and 4) |
| refWin | output | 1 | Reference window (counts 1 and 5) |
| decStrobe | output | 1 | Decision strobe (counts 2 and 6) |
| rstStrobe | output | 1 | Integrator reset strobe (counts 3 and 7) |
| freqUpDn | output | 1 | Latched frequency-error polarity |
| freqValid | output | 1 | One-cycle pulse on a new frequency decision |
| mmUpDn | output | 1 | Latched mismatch-error polarity |
| mmValid | output | 1 | One-cycle pulse on a new mismatch decision |

## Verification
The properties assume that `cmpDecision` and `injMark` are stable around each rising edge of the divided clock. They also assume that `rstN` goes low only asynchronously, as a whole-block reset. The bench drives every input on falling edges and samples on falling edges, so each value seen at a rising edge was settled half a period earlier. In slots other than the decision slots, the bench drives the comparator input with deliberately conflicting values, so a leak into a latched output would become visible.

// File: rtl/pwc_seq_pkg.sv
package pwc_seq_pkg;
  // Number of calibration destinations steered by the top count bit.
  localparam int NUM_PATHS = 2;
  localparam int PATH_FREQ = 0;
  localparam int PATH_MM   = 1;

  // Strobes from control to datapath and to the block outputs.
  typedef struct packed {
    logic                 enWin;
    logic                 refWin;
    logic                 decStrobe;
    logic                 rstStrobe;
    logic [NUM_PATHS-1:0] capture;
  } seqStrobe_t;
endpackage

// File: rtl/pwc_seq_ctrl.sv
module pwc_seq_ctrl
  import pwc_seq_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             injMark,
  output logic [CNT_W-1:0] cnt,
  output seqStrobe_t       strobe
);
  localparam int PH_W = CNT_W - 1;
  localparam logic [PH_W-1:0] SLOT_EN  = PH_W'(0);
  localparam logic [PH_W-1:0] SLOT_REF = PH_W'(1);
  localparam logic [PH_W-1:0] SLOT_DEC = PH_W'(2);
  localparam logic [PH_W-1:0] SLOT_RST = PH_W'(3);

  logic [PH_W-1:0] phase;
  logic            upperHalf;

  // Phase counter: a marker realigns it to slot 0, otherwise it wraps freely.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (injMark) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign phase     = cnt[PH_W-1:0];
  assign upperHalf = cnt[CNT_W-1];

  always_comb begin
    strobe.enWin     = (phase == SLOT_EN);
    strobe.refWin    = (phase == SLOT_REF);
    strobe.decStrobe = (phase == SLOT_DEC);
    strobe.rstStrobe = (phase == SLOT_RST);
    strobe.capture[PATH_FREQ] = strobe.decStrobe & ~upperHalf;
    strobe.capture[PATH_MM]   = strobe.decStrobe &  upperHalf;
  end
endmodule

// File: rtl/pwc_seq_dpath.sv
module pwc_seq_dpath
  import pwc_seq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  seqStrobe_t           strobe,
  input  logic                 cmpDecision,
  output logic [NUM_PATHS-1:0] upDn,
  output logic [NUM_PATHS-1:0] valid
);
  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        upDn[p]  <= 1'b0;
        valid[p] <= 1'b0;
      end else begin
        valid[p] <= strobe.capture[p];
        if (strobe.capture[p]) begin
          upDn[p] <= cmpDecision;
        end
      end
    end
  end
endmodule

// File: rtl/pwc_window_seq.sv
module pwc_window_seq
  import pwc_seq_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic clkDiv,
  input  logic rstN,
  input  logic injMark,
  input  logic cmpDecision,
  output logic enWin,
  output logic refWin,
  output logic decStrobe,
  output logic rstStrobe,
  output logic freqUpDn,
  output logic freqValid,
  output logic mmUpDn,
  output logic mmValid
);
  logic [CNT_W-1:0]     cnt;
  seqStrobe_t           strobe;
  logic [NUM_PATHS-1:0] upDn;
  logic [NUM_PATHS-1:0] valid;

  pwc_seq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk     (clkDiv),
    .rstN    (rstN),
    .injMark (injMark),
    .cnt     (cnt),
    .strobe  (strobe)
  );

  pwc_seq_dpath u_dpath (
    .clk         (clkDiv),
    .rstN        (rstN),
    .strobe      (strobe),
    .cmpDecision (cmpDecision),
    .upDn        (upDn),
    .valid       (valid)
  );

  assign enWin     = strobe.enWin     & rstN;
  assign refWin    = strobe.refWin    & rstN;
  assign decStrobe = strobe.decStrobe & rstN;
  assign rstStrobe = strobe.rstStrobe & rstN;
  assign freqUpDn  = upDn[PATH_FREQ];
  assign freqValid = valid[PATH_FREQ];
  assign mmUpDn    = upDn[PATH_MM];
  assign mmValid   = valid[PATH_MM];
endmodule

// File: rtl/pwc_seq_checker.sv
module pwc_seq_checker #(
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             injMark,
  input logic             cmpDecision,
  input logic [CNT_W-1:0] cnt,
  input logic             enWin,
  input logic             refWin,
  input logic             decStrobe,
  input logic             rstStrobe,
  input logic             freqUpDn,
  input logic             freqValid,
  input logic             mmUpDn,
  input logic             mmValid
);
  a_r2_one_window: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({enWin, refWin, decStrobe, rstStrobe}));

  a_r2_en_to_ref: assert property (@(posedge clk) disable iff (!rstN)
    enWin && !injMark |=> refWin);

  a_r2_ref_to_dec: assert property (@(posedge clk) disable iff (!rstN)
    refWin && !injMark |=> decStrobe);

  a_r2_dec_to_rst: assert property (@(posedge clk) disable iff (!rstN)
    decStrobe && !injMark |=> rstStrobe);

  a_r2_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == '1) && !injMark |=> (cnt == '0) && enWin);

  a_r3_realign: assert property (@(posedge clk) disable iff (!rstN)
    injMark |=> enWin && (cnt == '0));

  a_r4_freq_capture: assert property (@(posedge clk) disable iff (!rstN)
    decStrobe && !cnt[CNT_W-1] |=> freqValid && !mmValid && (freqUpDn == $past(cmpDecision)));

  a_r5_mm_capture: assert property (@(posedge clk) disable iff (!rstN)
    decStrobe && cnt[CNT_W-1] |=> mmValid && !freqValid && (mmUpDn == $past(cmpDecision)));

  a_r6_freq_hold: assert property (@(posedge clk) disable iff (!rstN)
    !freqValid |-> $stable(freqUpDn));

  a_r6_mm_hold: assert property (@(posedge clk) disable iff (!rstN)
    !mmValid |-> $stable(mmUpDn));

  a_r7_valid_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(freqValid && mmValid));
endmodule

bind pwc_window_seq pwc_seq_checker #(.CNT_W(CNT_W)) u_chk (
  .clk         (clkDiv),
  .rstN        (rstN),
  .injMark     (injMark),
  .cmpDecision (cmpDecision),
  .cnt         (cnt),
  .enWin       (enWin),
  .refWin      (refWin),
  .decStrobe   (decStrobe),
  .rstStrobe   (rstStrobe),
  .freqUpDn    (freqUpDn),
  .freqValid   (freqValid),
  .mmUpDn      (mmUpDn),
  .mmValid     (mmValid)
);

// File: tb/tb_pwc_window_seq.sv
module tb_pwc_window_seq;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic injMark = 1'b0;
  logic cmpDecision = 1'b0;
  logic enWin, refWin, decStrobe, rstStrobe;
  logic freqUpDn, freqValid, mmUpDn, mmValid;

  int  nTests = 0;
  int  nFail  = 0;
  bit  done   = 1'b0;
  logic prevFreq = 1'b0;
  logic prevMm   = 1'b0;

  // {frequency decision, mismatch decision, value driven in other slots}
  localparam logic [2:0] VEC [8] = '{3'b100, 3'b011, 3'b110, 3'b001,
                                     3'b101, 3'b010, 3'b111, 3'b000};

  pwc_window_seq dut (
    .clkDiv(clk), .rstN(rstN), .injMark(injMark), .cmpDecision(cmpDecision),
    .enWin(enWin), .refWin(refWin), .decStrobe(decStrobe), .rstStrobe(rstStrobe),
    .freqUpDn(freqUpDn), .freqValid(freqValid), .mmUpDn(mmUpDn), .mmValid(mmValid)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] winFor(input int s);
    return 4'b1000 >> (s % 4);
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    int fCount;
    int mCount;
    repeat (3) @(negedge clk);
    check("R1 outputs in reset", {enWin, refWin, decStrobe, rstStrobe,
          freqUpDn, freqValid, mmUpDn, mmValid}, 8'h00);
    rstN = 1'b1;
    #1;
    check("R1 count 0 after release", {enWin, refWin, decStrobe, rstStrobe}, 8'h8);
    @(negedge clk);
    check("R1 steps to count 1", {enWin, refWin, decStrobe, rstStrobe}, 8'h4);
    injMark = 1'b1;
    @(negedge clk);
    injMark = 1'b0;
    check("R3 marker realigns from count 1", {4'h0, enWin, refWin, decStrobe, rstStrobe}, 8'h8);

    // Table walk: eight intervals, free-running after the first alignment.
    for (int i = 0; i < 8; i++) begin
      logic f, m, junk;
      {f, m, junk} = VEC[i];
      for (int s = 0; s < 8; s++) begin
        check($sformatf("R2 windows v%0d slot %0d", i, s),
              {4'h0, enWin, refWin, decStrobe, rstStrobe}, {4'h0, winFor(s)});
        if (s == 3) begin
          check("R4 freqValid", {7'h0, freqValid}, 8'h1);
          check("R4 freqUpDn", {7'h0, freqUpDn}, {7'h0, f});
          prevFreq = f;
          check("R7 mmUpDn kept on freq capture", {7'h0, mmUpDn}, {7'h0, prevMm});
        end else begin
          check("R6 freqValid low", {7'h0, freqValid}, 8'h0);
          check("R6 freqUpDn held", {7'h0, freqUpDn}, {7'h0, prevFreq});
        end
        if (s == 7) begin
          check("R5 mmValid", {7'h0, mmValid}, 8'h1);
          check("R5 mmUpDn", {7'h0, mmUpDn}, {7'h0, m});
          prevMm = m;
          check("R7 freqUpDn kept on mm capture", {7'h0, freqUpDn}, {7'h0, prevFreq});
        end else begin
          check("R6 mmValid low", {7'h0, mmValid}, 8'h0);
          check("R6 mmUpDn held", {7'h0, mmUpDn}, {7'h0, prevMm});
        end
        cmpDecision = (s == 2) ? f : (s == 6) ? m : junk;
        @(negedge clk);
      end
    end

    // Now in slot 0. Advance to slot 5 with a 0 decision, then realign.
    cmpDecision = 1'b0;
    repeat (5) @(negedge clk);
    check("R2 slot 5 before marker", {4'h0, enWin, refWin, decStrobe, rstStrobe}, 8'h4);
    injMark = 1'b1;
    @(negedge clk);
    injMark = 1'b0;
    check("R3 marker realigns from count 5", {4'h0, enWin, refWin, decStrobe, rstStrobe}, 8'h8);
    @(negedge clk);
    check("R3 steps after realign", {4'h0, enWin, refWin, decStrobe, rstStrobe}, 8'h4);
    @(negedge clk);
    check("R2 slot 2 decision strobe", {7'h0, decStrobe}, 8'h1);
    cmpDecision = 1'b1;
    injMark = 1'b1;
    @(negedge clk);
    injMark = 1'b0;
    cmpDecision = 1'b0;
    check("R3 marker in decision slot gives count 0", {4'h0, enWin, refWin, decStrobe, rstStrobe}, 8'h8);
    check("R3 capture kept: freqValid", {7'h0, freqValid}, 8'h1);
    check("R3 capture kept: freqUpDn", {7'h0, freqUpDn}, 8'h1);

    // Free-running pulse count over 16 cycles.
    fCount = 0;
    mCount = 0;
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      if (freqValid) fCount++;
      if (mmValid) mCount++;
    end
    check("R8 freqValid pulses in 16 cycles", 8'(fCount), 8'd2);
    check("R8 mmValid pulses in 16 cycles", 8'(mCount), 8'd2);

    // Reset in the middle of operation.
    rstN = 1'b0;
    #1;
    check("R1 outputs cleared by reset", {enWin, refWin, decStrobe, rstStrobe,
          freqUpDn, freqValid, mmUpDn, mmValid}, 8'h00);
    repeat (2) @(negedge clk);
    check("R1 outputs held in reset", {enWin, refWin, decStrobe, rstStrobe,
          freqUpDn, freqValid, mmUpDn, mmValid}, 8'h00);
    rstN = 1'b1;
    #1;
    check("R1 count 0 after second release", {4'h0, enWin, refWin, decStrobe, rstStrobe}, 8'h8);
    @(negedge clk);
    check("R1 count 1 after second release", {4'h0, enWin, refWin, decStrobe, rstStrobe}, 8'h4);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule